// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines into a single interrupt output for a processor. Requests are sampled on the system clock into a pending register. They are filtered by a software mask and by the levels already being serviced, and the winner is chosen with input 0 as the highest priority. When the processor pulses acknowledge, the block drives a vector byte onto its read-data bus for one cycle. Unless automatic end-of-interrupt is enabled, it also marks that level as in service.

Software reaches the block through two addresses: a command address (address 0) and a data address (address 1). A configuration state machine handles the start-up word sequence. Its states are `ST_RUN` (normal operation), `ST_WANT_BASE`, `ST_WANT_CASC` and `ST_WANT_MODE`. A command write of 0x11 moves it from any state to `ST_WANT_BASE`. Each data write then advances it from `ST_WANT_BASE` to `ST_WANT_CASC`, from `ST_WANT_CASC` to `ST_WANT_MODE`, and from `ST_WANT_MODE` back to `ST_RUN`. In `ST_RUN`, data writes load the mask. Outside the start-up sequence, command writes are operational:
- a generic end-of-interrupt;
- a level-specific end-of-interrupt;
- a choice of which register command-address reads return.

The cascade word is only stored and brought out as a configuration output. On a primary controller it is a bit mask of inputs with a secondary attached. On a secondary controller it is the input number it hangs on.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the in-service register is 0, the mask is 0xFF, command-address reads return the pending register, the vector base and cascade word are 0, and `irq_o` is low.
- R2: A command write of 0x11 starts start-up. It clears the in-service register, sets the mask to 0xFF and selects the pending register for command reads. The next three data writes load, in order, the vector base, the cascade word (shown on `casc_cfg_o`) and the mode word. None of these three writes changes the mask.
- R3: In `ST_RUN`, a data write loads the mask and a data read returns it. Mask bit n = 1 blocks input n, so a masked request never raises `irq_o`.
- R4: Priority is fixed, with input 0 highest. `irq_o` is high in `ST_RUN` when the lowest-numbered unmasked pending input has no in-service bit set at its own level or any lower-numbered level.
- R5: An acknowledge pulse in cycle t makes `bus_rdata_o` equal to vector base plus the winning level in cycle t+1, with `vec_valid_o` high for that one cycle only. With automatic end-of-interrupt off, the winning level's in-service bit is set.
- R6: When mode-word bit 1 is 1 (automatic end-of-interrupt), an acknowledge delivers the vector but leaves the in-service register unchanged.
- R7: A command write of 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R8: A command write of 0x20 clears the lowest-numbered set in-service bit.
- R9: A command write of 0x0B makes later command-address reads return the in-service register. A command write of 0x0A makes them return the pending register.
- R10: If no request is forwarded when acknowledge arrives, the vector is base+7 and the in-service register is unchanged. This holds even when input 7 is masked.
- R11: Request inputs pass through one clock register: a change on `irq_req_i` affects `irq_o` only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | N_IN | Level-sensitive request lines, bit 0 highest priority |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; data appears the next cycle |
| bus_addr_i | input | 1 | 0 = command address, 1 = data address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data or acknowledge vector |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_ack_i | input | 1 | Acknowledge pulse from the processor |
| vec_valid_o | output | 1 | High for the one cycle that carries a vector |
| casc_cfg_o | output | DW | Stored cascade configuration word |

## Verification
A wrong in-service bit shows up in one of two ways. It can suppress `irq_o` for a pending lower-priority input, visible on the edge right after the acknowledge that set it. It can also appear directly on an in-service readback one cycle after the read strobe. A start-up state machine stuck in the wrong state shows up as an unchanged mask after a data write, or as a wrong base in the next vector. The directed scenarios therefore pair each acknowledge and end-of-interrupt with an in-service readback and an `irq_o` sample on the following cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_WANT_BASE = 2'd1,
        ST_WANT_CASC = 2'd2,
        ST_WANT_MODE = 2'd3
    } cfg_state_e;

    localparam logic [7:0] CMD_INIT    = 8'h11;
    localparam logic [7:0] CMD_EOI_ANY = 8'h20;
    localparam logic [7:0] CMD_EOI_LVL = 8'h60;
    localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR = 8'h0B;

    localparam int MODE_AEOI_BIT = 1;

endpackage

// File: rtl/irqc_cfg_fsm.sv
module irqc_cfg_fsm
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output cfg_state_e    state_o,
    output logic [DW-1:0] base_o,
    output logic [DW-1:0] casc_o,
    output logic          aeoi_o,
    output logic [N-1:0]  imr_o,
    output logic          sel_isr_o,
    output logic          init_o,
    output logic          eoi_any_o,
    output logic          eoi_lvl_vld_o,
    output logic [LW-1:0] eoi_lvl_o
);

    cfg_state_e state_q, state_d;
    logic cmd_wr, dat_wr;

    assign cmd_wr = wr_en && (addr == 1'b0);
    assign dat_wr = wr_en && (addr == 1'b1);

    // command decode
    always_comb begin
        init_o        = cmd_wr && (wdata == CMD_INIT);
        eoi_any_o     = cmd_wr && (wdata == CMD_EOI_ANY);
        eoi_lvl_vld_o = cmd_wr && (wdata[DW-1:LW] == CMD_EOI_LVL[DW-1:LW]);
        eoi_lvl_o     = wdata[LW-1:0];
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (init_o) begin
            state_d = ST_WANT_BASE;
        end else if (dat_wr) begin
            unique case (state_q)
                ST_RUN:       state_d = ST_RUN;
                ST_WANT_BASE: state_d = ST_WANT_CASC;
                ST_WANT_CASC: state_d = ST_WANT_MODE;
                ST_WANT_MODE: state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_o    <= '0;
            casc_o    <= '0;
            aeoi_o    <= 1'b0;
            imr_o     <= '1;
            sel_isr_o <= 1'b0;
        end else if (init_o) begin
            imr_o     <= '1;
            sel_isr_o <= 1'b0;
        end else begin
            if (cmd_wr && wdata == CMD_SEL_ISR) sel_isr_o <= 1'b1;
            if (cmd_wr && wdata == CMD_SEL_IRR) sel_isr_o <= 1'b0;
            if (dat_wr) begin
                unique case (state_q)
                    ST_RUN:       imr_o  <= wdata[N-1:0];
                    ST_WANT_BASE: base_o <= wdata;
                    ST_WANT_CASC: casc_o <= wdata;
                    ST_WANT_MODE: aeoi_o <= wdata[MODE_AEOI_BIT];
                endcase
            end
        end
    end

    assign state_o = state_q;

    // R2: start-up command forces mask, read select and state
    p_init_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> (imr_o == '1 && !sel_isr_o && state_o == ST_WANT_BASE));

    // R2: start-up data words leave the mask alone
    p_mask_kept_in_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_RUN && !init_o) |=> $stable(imr_o));

    // R3: a data write in normal operation lands in the mask
    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && state_o == ST_RUN) |=> (imr_o == $past(wdata[N-1:0])));

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  imr_i,
    input  logic [N-1:0]  isr_i,
    output logic          fwd_vld_o,
    output logic [LW-1:0] fwd_lvl_o,
    output logic          top_isr_vld_o,
    output logic [LW-1:0] top_isr_lvl_o
);

    logic [N-1:0] cand;
    logic [N-1:0] blocked;
    logic         cand_any;

    assign cand = irr_i & ~imr_i;

    // level i is blocked by any in-service bit at i or above in priority
    for (genvar gi = 0; gi < N; gi++) begin : g_block
        assign blocked[gi] = |isr_i[gi:0];
    end

    always_comb begin
        cand_any  = 1'b0;
        fwd_lvl_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                cand_any  = 1'b1;
                fwd_lvl_o = LW'(i);
            end
        end
        fwd_vld_o = cand_any && !blocked[fwd_lvl_o];
    end

    always_comb begin
        top_isr_vld_o = 1'b0;
        top_isr_lvl_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (isr_i[i]) begin
                top_isr_vld_o = 1'b1;
                top_isr_lvl_o = LW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_isr_ctl.sv
module irqc_isr_ctl #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          ack_i,
    input  logic          fwd_vld_i,
    input  logic [LW-1:0] fwd_lvl_i,
    input  logic          aeoi_i,
    input  logic          eoi_any_i,
    input  logic          top_vld_i,
    input  logic [LW-1:0] top_lvl_i,
    input  logic          eoi_lvl_vld_i,
    input  logic [LW-1:0] eoi_lvl_i,
    output logic [N-1:0]  isr_o
);

    logic [N-1:0] set_v, clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (ack_i && fwd_vld_i && !aeoi_i) set_v[fwd_lvl_i] = 1'b1;
        if (eoi_any_i && top_vld_i)        clr_v[top_lvl_i] = 1'b1;
        if (eoi_lvl_vld_i)                 clr_v[eoi_lvl_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      isr_o <= '0;
        else if (init_i) isr_o <= '0;
        else             isr_o <= (isr_o & ~clr_v) | set_v;
    end

    // R5: a real acknowledge marks its level in service
    p_ack_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && fwd_vld_i && !aeoi_i && !init_i) |=> isr_o[$past(fwd_lvl_i)]);

    // R6: automatic end-of-interrupt leaves in-service state alone
    p_aeoi_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && aeoi_i && !init_i && !eoi_any_i && !eoi_lvl_vld_i) |=> $stable(isr_o));

    // R7: specific end-of-interrupt clears its level
    p_eoi_lvl_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_lvl_vld_i && !(ack_i && fwd_vld_i)) |=> !isr_o[$past(eoi_lvl_i)]);

    // R10: acknowledge with nothing forwarded keeps in-service state
    p_spurious_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !fwd_vld_i && !init_i && !eoi_any_i && !eoi_lvl_vld_i) |=> $stable(isr_o));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int DW   = 8,
    localparam int LW  = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_req_i,
    input  logic            bus_wr_i,
    input  logic            bus_rd_i,
    input  logic            bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic            irq_o,
    input  logic            irq_ack_i,
    output logic            vec_valid_o,
    output logic [DW-1:0]   casc_cfg_o
);

    cfg_state_e      state;
    logic [N_IN-1:0] irr_q, imr, isr;
    logic [DW-1:0]   base;
    logic            aeoi, sel_isr, init_cmd, eoi_any, eoi_lvl_vld;
    logic [LW-1:0]   eoi_lvl, fwd_lvl, top_lvl;
    logic            fwd_vld, top_vld;
    logic [LW-1:0]   vec_lvl;
    logic [DW-1:0]   vector;

    irqc_cfg_fsm #(.N(N_IN), .DW(DW)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (bus_wr_i),
        .addr          (bus_addr_i),
        .wdata         (bus_wdata_i),
        .state_o       (state),
        .base_o        (base),
        .casc_o        (casc_cfg_o),
        .aeoi_o        (aeoi),
        .imr_o         (imr),
        .sel_isr_o     (sel_isr),
        .init_o        (init_cmd),
        .eoi_any_o     (eoi_any),
        .eoi_lvl_vld_o (eoi_lvl_vld),
        .eoi_lvl_o     (eoi_lvl)
    );

    irqc_resolver #(.N(N_IN)) u_res (
        .irr_i         (irr_q),
        .imr_i         (imr),
        .isr_i         (isr),
        .fwd_vld_o     (fwd_vld),
        .fwd_lvl_o     (fwd_lvl),
        .top_isr_vld_o (top_vld),
        .top_isr_lvl_o (top_lvl)
    );

    irqc_isr_ctl #(.N(N_IN)) u_isr (
        .clk           (clk),
        .rst_n         (rst_n),
        .init_i        (init_cmd),
        .ack_i         (irq_ack_i),
        .fwd_vld_i     (fwd_vld),
        .fwd_lvl_i     (fwd_lvl),
        .aeoi_i        (aeoi),
        .eoi_any_i     (eoi_any),
        .top_vld_i     (top_vld),
        .top_lvl_i     (top_lvl),
        .eoi_lvl_vld_i (eoi_lvl_vld),
        .eoi_lvl_i     (eoi_lvl),
        .isr_o         (isr)
    );

    // request sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= irq_req_i;
    end

    // lowest priority level stands in when nothing is forwarded
    assign vec_lvl = fwd_vld ? fwd_lvl : LW'(N_IN - 1);
    assign vector  = base + DW'(vec_lvl);
    assign irq_o   = fwd_vld && (state == ST_RUN);

    // read data and vector output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
            vec_valid_o <= 1'b0;
        end else begin
            vec_valid_o <= irq_ack_i;
            if (irq_ack_i)
                bus_rdata_o <= vector;
            else if (bus_rd_i)
                bus_rdata_o <= bus_addr_i ? DW'(imr) : (sel_isr ? DW'(isr) : DW'(irr_q));
        end
    end

    // R5: vector strobe only follows an acknowledge
    p_vec_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(irq_ack_i));

    // R3: interrupt output never raised by masked inputs only
    p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irr_q & ~imr) != '0));

    // R4: forwarded level is never already in service
    p_fwd_not_in_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !isr[fwd_lvl]);

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req_i = '0;
    logic       bus_wr_i = 1'b0;
    logic       bus_rd_i = 1'b0;
    logic       bus_addr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       irq_o;
    logic       irq_ack_i = 1'b0;
    logic       vec_valid_o;
    logic [7:0] casc_cfg_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    prio_irq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (irq_req_i),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o),
        .irq_ack_i   (irq_ack_i),
        .vec_valid_o (vec_valid_o),
        .casc_cfg_o  (casc_cfg_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic set_req(input logic [7:0] r);
        irq_req_i = r;
        @(negedge clk);
    endtask

    task automatic read_isr(output logic [7:0] d);
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
    endtask

    task automatic ack(input string req, input logic [7:0] exp_vec);
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
        check(req, bus_rdata_o, exp_vec);
        check(req, 8'(vec_valid_o), 8'h01);
        @(negedge clk);
        check(req, 8'(vec_valid_o), 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", 8'(irq_o), 8'h00);
        check("R1 casc", casc_cfg_o, 8'h00);
        rd(1'b1, d); check("R1 mask", d, 8'hFF);
        rd(1'b0, d); check("R1 pending", d, 8'h00);
        read_isr(d); check("R1 isr", d, 8'h00);
        wr(1'b0, 8'h0A);
    endtask

    task automatic t_init();
        logic [7:0] d;
        wr(1'b1, 8'h5A);
        rd(1'b1, d); check("R3 mask load", d, 8'h5A);
        wr(1'b0, 8'h11);
        rd(1'b1, d); check("R2 mask forced", d, 8'hFF);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        rd(1'b1, d); check("R2 mask kept", d, 8'hFF);
        wr(1'b1, 8'h01);
        check("R2 casc", casc_cfg_o, 8'h04);
        rd(1'b1, d); check("R2 mask after", d, 8'hFF);
    endtask

    task automatic two_in_service();
        set_req(8'h28);
        check("R4 lvl3 raises", 8'(irq_o), 8'h01);
        ack("R5 vector lvl3", 8'h23);
        check("R4 blocked by own", 8'(irq_o), 8'h00);
        set_req(8'h2A);
        check("R4 lvl1 raises", 8'(irq_o), 8'h01);
        ack("R5 vector lvl1", 8'h21);
    endtask

    task automatic t_priority_eoi();
        logic [7:0] d;
        wr(1'b1, 8'hF0);
        rd(1'b1, d); check("R3 mask read", d, 8'hF0);
        set_req(8'h30);
        check("R3 masked silent", 8'(irq_o), 8'h00);
        two_in_service();
        read_isr(d); check("R5 isr two", d, 8'h0A);
        wr(1'b0, 8'h63);
        read_isr(d); check("R7 specific", d, 8'h02);
        // lvl3 still pending but lvl1 in service blocks it
        check("R4 blocked by higher", 8'(irq_o), 8'h00);
        wr(1'b0, 8'h20);
        read_isr(d); check("R8 generic single", d, 8'h00);
        two_in_service();
        wr(1'b0, 8'h20);
        read_isr(d); check("R8 generic lowest", d, 8'h08);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); check("R9 pending sel", d, 8'h2A);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); check("R9 isr sel", d, 8'h08);
        wr(1'b0, 8'h63);
        read_isr(d); check("R7 clear last", d, 8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        set_req(8'h00);
        check("R10 idle", 8'(irq_o), 8'h00);
        ack("R10 vector", 8'h27);
        read_isr(d); check("R10 isr kept", d, 8'h00);
    endtask

    task automatic t_sampling();
        irq_req_i = 8'h01;
        #1;
        check("R11 not yet", 8'(irq_o), 8'h00);
        @(negedge clk);
        check("R11 after edge", 8'(irq_o), 8'h01);
    endtask

    task automatic t_aeoi();
        logic [7:0] d;
        ack("R5 vector lvl0", 8'h20);
        read_isr(d); check("R5 isr lvl0", d, 8'h01);
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h03);
        check("R2 casc secondary", casc_cfg_o, 8'h02);
        read_isr(d); check("R2 isr cleared", d, 8'h00);
        check("R2 masked after init", 8'(irq_o), 8'h00);
        wr(1'b1, 8'h00);
        set_req(8'h10);
        check("R6 raise", 8'(irq_o), 8'h01);
        ack("R6 vector", 8'h44);
        read_isr(d); check("R6 isr untouched", d, 8'h00);
        check("R6 still raised", 8'(irq_o), 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_priority_eoi();
        t_spurious();
        t_sampling();
        t_aeoi();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule